// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues clause 22 management transactions to an Ethernet PHY over a two-wire serial bus. The bus is a management clock, MDC, and a shared bidirectional data line, MDIO. A host starts a transaction with a one-cycle strobe, giving the direction, a PHY address, a register address and, for writes, 16 bits of data. The block then runs the whole frame by itself. It ends with a one-cycle completion pulse, and for reads it presents the returned register value at that pulse.

MDC comes from a counter that divides the system clock. The length of a half period is derived from the system clock frequency and from the highest MDC rate allowed. The data line is handled through three separate signals: a driven value, an output enable and a sampled input. The pad that joins them lies outside this block.

A read frame has three parts:
- a preamble of ones;
- a 16-bit command that begins with two extra ones;
- 19 clocks with the line released, whose middle 16 bits are kept as the result.

A write frame sends the preamble, then a 32-bit word, then two clocks with the line released. A register address of 32 or above is refused at once, with no activity on the bus.

Top module: `mdio_master`

## Requirements
- R1: Each MDC half period lasts exactly HALF_CYC system cycles, where HALF_CYC = ceil(SYS_CLK_HZ / (2 * MDC_MAX_HZ)). This is 50 cycles for the defaults of 250 MHz and 2.5 MHz. MDC stays low whenever the block is idle.
- R2: Every accepted transaction starts with 33 MDC rising edges during which MDIO is driven to 1 with its output enable high.
- R3: A read sends 16 driven bits after the preamble, MSB first, in this order: 1, 1, 0, 1, 1, 0, then the PHY address (bit 4 first), then register address bits 4:0.
- R4: After the read command, the output enable is low for 19 MDC rising edges. Number the bits sampled on those edges j = 0..18. The read result is bits j = 2..17, with j = 2 as the most significant bit.
- R5: A write sends 32 driven bits after the preamble, MSB first, in this order: 0, 1, 0, 1, then the PHY address, register address bits 4:0, then 1, 0, then the 16 data bits.
- R6: A write frame ends with 2 more MDC rising edges with the output enable low. A write frame therefore has 67 rising edges in total, and a read frame has 68.
- R7: A start whose register address is 32 or above (bit 5 set) produces no MDC edge and does not raise busy. Done rises in the next cycle. For a read, the returned data is 0xFFFF. For a write, the returned data keeps its previous value.
- R8: MDIO and its output enable change only while MDC is low. MDIO input is sampled in the last system cycle of each MDC low phase, so any value the input takes while MDC is high has no effect.
- R9: Busy is high from the cycle after an accepted start until the cycle in which done is raised. A start strobe seen while busy is high changes neither the frame in progress nor the number of completions.
- R10: The MDIO output enable is low out of reset and whenever busy is low.
- R11: Done is a one-cycle pulse, one for each start accepted while idle. At that pulse, read data holds the result of a read, or the previous value after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle transaction request |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | REG_AW (6) | Register address; values of 32 and above are refused |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | 16 | Read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on MDIO |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Sampled MDIO value |

## Verification
A wrong bit counter or a wrong sequencer state shows at the completion pulse, because the number of MDC rising edges in the frame no longer equals 67 or 68. A corrupted shift word is caught on the first rising edge that carries a wrong driven bit. A wrong release point is caught on the edge where the output enable has the wrong level. A divider fault is caught at the end of the very first half period. The bench drives the opposite of the correct MDIO input while MDC is high, so a design that samples in the wrong phase returns wrong read data at the next done.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CMD,
    ST_RX,
    ST_TAIL
  } mdio_state_e;

  localparam int unsigned PRE_BITS  = 33;
  localparam int unsigned RD_BITS   = 16;
  localparam int unsigned WR_BITS   = 32;
  localparam int unsigned RX_BITS   = 19;
  localparam int unsigned TAIL_BITS = 2;
  localparam int unsigned CNT_W     = 6;

  // Read command: two extra ones + start + opcode + addresses, placed in the upper half.
  function automatic logic [31:0] rd_word(input logic [4:0] phy, input logic [4:0] ra);
    logic [31:0] w;
    w = (32'h0000_00F6 << 10) | (32'(phy) << 5) | 32'(ra);
    return {w[15:0], 16'h0000};
  endfunction

  function automatic logic [31:0] wr_word(input logic [4:0] phy, input logic [4:0] ra,
                                          input logic [15:0] d);
    return 32'h5002_0000 | (32'(phy) << 23) | (32'(ra) << 18) | 32'(d);
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned HALF_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == '0);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= RELOAD;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= RELOAD;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_mdc_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o);
endmodule

// File: rtl/mdio_shift.sv
module mdio_shift #(
  parameter int unsigned TX_W = 32,
  parameter int unsigned DW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TX_W-1:0] word_i,
  input  logic            shift_i,
  input  logic            cap_i,
  input  logic            mdi_i,
  output logic            tx_bit_o,
  output logic [DW-1:0]   rx_word_o
);
  logic [TX_W-1:0] sr_q;
  logic [DW:0]     acc_q;  // data window plus the trailing idle bit

  assign tx_bit_o  = sr_q[TX_W-1];
  assign rx_word_o = acc_q[DW:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      acc_q <= '0;
    end else begin
      if (load_i)       sr_q <= word_i;
      else if (shift_i) sr_q <= {sr_q[TX_W-2:0], 1'b0};
      if (load_i)       acc_q <= '0;
      else if (cap_i)   acc_q <= {acc_q[DW-1:0], mdi_i};
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ  = 250_000_000,
  parameter int unsigned MDC_MAX_HZ  = 2_500_000,
  parameter int unsigned REG_AW      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [4:0]        phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [15:0]       wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int unsigned HALF_RAW = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
  localparam int unsigned HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  mdio_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_rd_q;
  logic             done_q;
  logic [15:0]      rdata_q;

  logic        run, rise, fall;
  logic        bad_addr, accept, load, shift, cap, tx_bit;
  logic [31:0] tx_word;
  logic [15:0] rx_word;

  assign bad_addr = |reg_addr_i[REG_AW-1:5];
  assign accept   = (state_q == ST_IDLE) && start_i && !bad_addr;
  assign load     = accept;
  assign tx_word  = rd_i ? rd_word(phy_addr_i, reg_addr_i[4:0])
                         : wr_word(phy_addr_i, reg_addr_i[4:0], wdata_i);
  assign shift    = (state_q == ST_CMD) && fall && (cnt_q != '0);
  assign cap      = (state_q == ST_RX) && rise;
  assign run      = (state_q != ST_IDLE);

  mdio_clk_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shift #(.TX_W(32), .DW(16)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .word_i    (tx_word),
    .shift_i   (shift),
    .cap_i     (cap),
    .mdi_i     (mdio_i),
    .tx_bit_o  (tx_bit),
    .rx_word_o (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && bad_addr) begin
            done_q <= 1'b1;
            if (rd_i) rdata_q <= 16'hFFFF;
          end else if (start_i) begin
            state_q <= ST_PRE;
            cnt_q   <= CNT_W'(PRE_BITS - 1);
            is_rd_q <= rd_i;
          end
        end
        ST_PRE: if (fall) begin
          if (cnt_q == '0) begin
            state_q <= ST_CMD;
            cnt_q   <= is_rd_q ? CNT_W'(RD_BITS - 1) : CNT_W'(WR_BITS - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_CMD: if (fall) begin
          if (cnt_q == '0) begin
            state_q <= is_rd_q ? ST_RX : ST_TAIL;
            cnt_q   <= is_rd_q ? CNT_W'(RX_BITS - 1) : CNT_W'(TAIL_BITS - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_RX: if (fall) begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            rdata_q <= rx_word;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_TAIL: if (fall) begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = run;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign mdio_oe_o = (state_q == ST_PRE) || (state_q == ST_CMD);
  assign mdio_o    = (state_q == ST_PRE) ? 1'b1 : ((state_q == ST_CMD) && tx_bit);

  assert_oe_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o);

  assert_hold_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_bad_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && bad_addr) |=> (done_o && !busy_o && !mdc_o));

  assert_busy_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 50;  // ceil(250 MHz / (2 * 2.5 MHz))
  localparam int WDOG = 200_000;

  typedef struct {
    bit          rd;
    bit          bad;
    logic [4:0]  phy;
    logic [5:0]  ra;
    logic [15:0] wd;
    logic [15:0] exp_rdata;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [4:0] phy = '0;
  logic [5:0] ra = '0;
  logic [15:0] wd = '0;
  logic busy, done, mdc, mdo, oe, mdi;
  logic [15:0] rdata;

  int n_chk = 0, n_bad = 0, n_done = 0, n_req = 0;
  item_t sb_q[$];
  logic [15:0] resp = '0;
  logic [15:0] last_rdata = '0;
  int rise_cnt = 0, phase_len = 0;
  logic mdc_q = 1'b0, busy_q = 1'b0;
  bit cap_oe [0:79];
  bit cap_do [0:79];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mdio_master u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd),
    .phy_addr_i(phy), .reg_addr_i(ra), .wdata_i(wd),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(oe), .mdio_i(mdi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // PHY model: good bit during MDC low, inverted garbage while MDC high (R8).
  function automatic bit phy_bit(input int k);
    int j;
    j = k - 49;
    if (j < 0 || j > 18) return 1'b1;
    if (j == 0) return 1'b1;
    if (j == 1) return 1'b0;
    if (j == 18) return 1'b1;
    return resp[17 - j];
  endfunction

  assign mdi = mdc ? ~phy_bit(rise_cnt) : phy_bit(rise_cnt);

  function automatic bit exp_bit(input item_t it, input int k, output bit e_oe);
    logic [15:0] rc;
    logic [31:0] wc;
    rc = {2'b11, 2'b01, 2'b10, it.phy, it.ra[4:0]};
    wc = {2'b01, 2'b01, it.phy, it.ra[4:0], 2'b10, it.wd};
    e_oe = 1'b1;
    if (k < 33) return 1'b1;
    if (it.rd && k < 49) return rc[48 - k];
    if (!it.rd && k < 65) return wc[64 - k];
    e_oe = 1'b0;
    return 1'b0;
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy || !oe, "R10 oe while idle", oe, 0);
      if (mdc != mdc_q) begin
        chk(phase_len == HALF, "R1 half period", phase_len, HALF);
        phase_len = 1;
      end else if (busy || mdc) phase_len++;
      if (busy && !busy_q) phase_len = 1;
      if (mdc && !mdc_q) begin
        if (rise_cnt < 80) begin
          cap_oe[rise_cnt] = oe;
          cap_do[rise_cnt] = mdo;
        end
        rise_cnt++;
      end
      if (done) begin
        n_done++;
        if (sb_q.size() == 0) chk(0, "R11 unexpected done", 1, 0);
        else begin
          item_t it;
          int exp_len, e_do_err, e_oe_err;
          it = sb_q.pop_front();
          exp_len = it.bad ? 0 : (it.rd ? 68 : 67);
          chk(rise_cnt == exp_len, it.bad ? "R7 no bus edges" : "R6 frame length",
              rise_cnt, exp_len);
          chk(!busy, "R9 busy low at done", busy, 0);
          e_do_err = 0; e_oe_err = 0;
          for (int k = 0; k < exp_len && k < 80; k++) begin
            bit eo, ed;
            ed = exp_bit(it, k, eo);
            if (cap_oe[k] != eo) e_oe_err++;
            if (eo && cap_do[k] != ed) e_do_err++;
          end
          chk(e_oe_err == 0, it.rd ? "R4 release" : "R6 release", e_oe_err, 0);
          chk(e_do_err == 0, it.rd ? "R3 R2 read cmd bits" : "R5 R2 write bits", e_do_err, 0);
          chk(rdata == it.exp_rdata, it.rd ? "R4 R8 read data" : "R11 data held",
              rdata, it.exp_rdata);
        end
        rise_cnt = 0;
      end
    end
    mdc_q  = mdc;
    busy_q = busy;
  end

  task automatic txn(input bit r, input logic [4:0] p, input logic [5:0] a,
                     input logic [15:0] d, input logic [15:0] rsp, input bit poke);
    item_t it;
    it.rd = r; it.bad = a[5]; it.phy = p; it.ra = a; it.wd = d;
    if (r) last_rdata = a[5] ? 16'hFFFF : rsp;
    it.exp_rdata = last_rdata;
    sb_q.push_back(it);
    n_req++;
    resp = rsp;
    @(negedge clk);
    start = 1'b1; rd = r; phy = p; ra = a; wd = d;
    @(negedge clk);
    start = 1'b0; rd = ~r; phy = ~p; wd = ~d;
    if (a[5]) begin
      chk(done && !busy, "R7 done next cycle", {busy, done}, 1);
    end else begin
      chk(busy, "R9 busy after start", busy, 1);
      if (poke) begin
        repeat (300) @(negedge clk);
        start = 1'b1; rd = 1'b1; phy = 5'd3; ra = 6'd2;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R9 busy mid frame", busy, 1);
      end
      while (!done) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !oe && !mdc, "R10 reset outputs", {busy, done, oe, mdc}, 0);
    chk(rdata == 16'h0, "R11 reset rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mdc && !busy, "R1 idle mdc low", mdc, 0);
    txn(1, 5'd1,  6'd1,  16'h0000, 16'hA5C3, 0);
    txn(0, 5'd31, 6'd0,  16'h1234, 16'h0000, 0);
    txn(1, 5'd0,  6'd31, 16'h0000, 16'h0001, 0);
    txn(1, 5'd31, 6'd17, 16'h0000, 16'h8000, 0);
    txn(0, 5'd10, 6'd4,  16'hFFFF, 16'h0000, 0);
    txn(1, 5'd7,  6'd32, 16'h0000, 16'h0000, 0);
    txn(1, 5'd12, 6'd9,  16'h0000, 16'h5A5A, 0);
    txn(0, 5'd12, 6'd63, 16'hBEEF, 16'h0000, 0);
    txn(0, 5'd5,  6'd21, 16'h0000, 16'h0000, 1);
    repeat (20) @(negedge clk);
    chk(n_done == n_req, "R9 R11 done count", n_done, n_req);
    chk(sb_q.size() == 0, "R11 scoreboard empty", sb_q.size(), 0);
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < WDOG && !finished; c++) @(posedge clk);
    if (!finished) chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule